// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block maps addresses that arrive from PCI bus masters into system memory addresses. Software programs a small set of windows through a register port. Each window holds a base, a size mask and a translated base. A window that matches passes the address through a direct offset or through a page table. In the page table case the block fetches one 64-bit entry from memory over a request/response port.

Addresses that fit in 32 bits are single-cycle addresses. They are matched against the windows in priority order, and a control bit can carve a hole out of low memory. Wider dual-cycle addresses reach one of two places: a fixed large window that exposes the low 35 bits of the address, or the last window used as a dual-cycle page-table window. The translator handles one request at a time. Every outcome is a one-cycle result carrying the system address and the offset mask, or a fault.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset the last window's base register reads 0x2, every other window register and the control register read 0, no window is enabled, `req_ready` is 1, and `res_valid` and `pte_req_valid` are 0.
- R2: The register address is {kind[1:0], window index}, where kind 0 is base, 1 is mask, 2 is translated base and 3 with index 0 is control. A write keeps base bits 31:20 and 1:0. For the last window it keeps base bits 39, 31:20 and 0 and forces bit 1 to 1. Masks keep bits 31:20, translated bases keep bits 34:10, and control keeps the bits of 0x1C_FF0F_C7FF.
- R3: A window takes part only when base bit 0 is 1. It matches a 32-bit address when (addr AND NOT(mask OR 0xFFFFF)) equals base bits 31:20 followed by 20 zeros.
- R4: A matching window with base bit 1 clear produces `res_addr` = (tba AND NOT ext) OR (addr AND ext) and `res_mask` = ext, where ext = mask OR 0xFFFFF. The result is valid in the cycle after the request is accepted.
- R5: A matching window with base bit 1 set raises `pte_req_valid` for exactly one cycle, in the cycle after acceptance, with `pte_req_addr` = (tba AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). `req_ready` stays 0 until the response has been taken.
- R6: If the returned entry has bit 0 set, the result appears in the cycle after `pte_rsp_valid`, with `res_addr` = ((pte AND 0x3FFFFE)<<12) OR (addr AND 0x1FFF) and `res_mask` = 0x1FFF. If bit 0 is clear, the result is a fault.
- R7: A single-cycle address (at most 0xFFFF_FFFF) tries the windows from index 0 upward and the first match wins. The last window takes part only while its base bit 39 is 0.
- R8: While control bit 5 is 1, single-cycle addresses from 0x8_0000 to 0xF_FFFF inclusive fault even when a window matches. Addresses just below the range still translate.
- R9: Addresses from 0x100_0000_0000 up to but not including 0x200_0000_0000 give `res_addr` = addr[34:0] and `res_mask` = 0x7_FFFF_FFFF when control bit 6 is 1, and fault when it is 0.
- R10: Addresses from 0x800_0000_0000 to 0xFFF_FFFF_FFFF use the last window as a page-table window only when its base bits 39 and 0 are both 1. In that case the entry address is (tba AND 0x7_FFC0_0000) OR ((addr AND 0xFFFF_E000)>>10). Otherwise they fault.
- R11: A fault is reported as `res_valid` with `res_fault` = 1, and with `res_addr` and `res_mask` both 0.
- R12: Dual-cycle addresses outside both dual-cycle ranges, such as 0x1_0000_0000 or 0x7FF_FFFF_FFFF, fault without consulting any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register select {kind, window index} |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle and able to accept |
| req_addr | input | 44 | PCI address to translate |
| pte_req_valid | output | 1 | One-cycle page table entry read request |
| pte_req_addr | output | 35 | System address of the entry |
| pte_rsp_valid | input | 1 | Entry data returned |
| pte_rsp_data | input | 64 | Entry data |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Translation failed, no access allowed |
| res_addr | output | 35 | Translated system address |
| res_mask | output | 35 | Offset mask of the mapping |

## Verification
Configuration state is held only in the window and control registers. A wrong register bit therefore shows on the next read of that register, and on the first request that exercises it. The result then lands in the wrong window, takes the wrong hole or big-window decision, or carries a wrong address or mask one cycle after acceptance. A wrong sequencer state shows within a cycle or two as a missing or repeated entry request, `req_ready` high while a fetch is pending, or a result strobe that follows neither an accepted request nor an entry response. The directed tests aim at the window edges, the hole edges and the dual-cycle range edges, where a wrong comparison changes the outcome.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

    localparam int PCI_AW  = 44;
    localparam int SYS_AW  = 35;
    localparam int CSR_DW  = 64;
    localparam int BASE_W  = 40;
    localparam int PG_OFF_W = 13;

    localparam int BASE_EN_BIT  = 0;
    localparam int BASE_SG_BIT  = 1;
    localparam int BASE_DAC_BIT = 39;
    localparam int CTL_HOLE_BIT = 5;
    localparam int CTL_BIG_BIT  = 6;

    localparam logic [BASE_W-1:0] BASE_KEEP      = 40'h00_FFF0_0003;
    localparam logic [BASE_W-1:0] LAST_BASE_KEEP = 40'h80_FFF0_0001;
    localparam logic [BASE_W-1:0] LAST_BASE_SET  = 40'h00_0000_0002;
    localparam logic [31:0]       MASK_KEEP      = 32'hFFF0_0000;
    localparam logic [SYS_AW-1:0] TBA_KEEP       = 35'h7_FFFF_FC00;
    localparam logic [CSR_DW-1:0] CTL_KEEP       = 64'h0000_001C_FF0F_C7FF;

    localparam logic [31:0]       WIN_FLOOR      = 32'h000F_FFFF;
    localparam logic [31:0]       SG_IDX_BITS    = 32'h000F_E000;
    localparam logic [31:0]       HOLE_LO        = 32'h0008_0000;
    localparam logic [31:0]       HOLE_HI        = 32'h000F_FFFF;
    localparam logic [SYS_AW-1:0] BIG_MASK       = 35'h7_FFFF_FFFF;
    localparam logic [SYS_AW-1:0] PG_MASK        = 35'h0_0000_1FFF;
    localparam logic [SYS_AW-1:0] DAC_TBA_KEEP   = 35'h7_FFC0_0000;
    localparam logic [31:0]       DAC_IDX_BITS   = 32'hFFFF_E000;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [31:0]       mask;
        logic [SYS_AW-1:0] tba;
    } win_cfg_t;

    typedef enum logic [1:0] {
        CK_BASE = 2'd0,
        CK_MASK = 2'd1,
        CK_TBA  = 2'd2,
        CK_CTL  = 2'd3
    } csr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        OC_FAULT  = 2'd0,
        OC_DIRECT = 2'd1,
        OC_TABLE  = 2'd2
    } outcome_e;

    typedef struct packed {
        xl_state_e             st;
        logic                  res_v;
        logic                  res_f;
        logic [SYS_AW-1:0]     res_a;
        logic [SYS_AW-1:0]     res_m;
        logic [SYS_AW-1:0]     pte_a;
        logic [PG_OFF_W-1:0]   off;
    } xl_t;

endpackage

// File: rtl/dwx_csr.sv
module dwx_csr import dwx_pkg::*; #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int CSR_AW = IDX_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_we,
    input  logic [CSR_AW-1:0]         csr_addr,
    input  logic [CSR_DW-1:0]         csr_wdata,
    output logic [CSR_DW-1:0]         csr_rdata,
    output win_cfg_t [NUM_WIN-1:0]    win_o,
    output logic [CSR_DW-1:0]         ctl_o
);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic [CSR_DW-1:0]      ctl;
    } csr_t;

    csr_t      st_d, st_q;
    csr_kind_e kind;
    logic [IDX_W-1:0] idx;

    assign kind = csr_kind_e'(csr_addr[CSR_AW-1 -: 2]);
    assign idx  = csr_addr[IDX_W-1:0];

    function automatic csr_t reset_value();
        csr_t v;
        v = '0;
        v.win[NUM_WIN-1].base = LAST_BASE_SET;
        return v;
    endfunction

    always_comb begin
        st_d = st_q;
        if (csr_we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (int'(idx) == i) begin
                    case (kind)
                        CK_BASE: begin
                            if (i == NUM_WIN - 1) begin
                                st_d.win[i].base = (csr_wdata[BASE_W-1:0] & LAST_BASE_KEEP) | LAST_BASE_SET;
                            end else begin
                                st_d.win[i].base = csr_wdata[BASE_W-1:0] & BASE_KEEP;
                            end
                        end
                        CK_MASK: st_d.win[i].mask = csr_wdata[31:0] & MASK_KEEP;
                        CK_TBA:  st_d.win[i].tba  = csr_wdata[SYS_AW-1:0] & TBA_KEEP;
                        default: ;
                    endcase
                end
            end
            if (kind == CK_CTL && idx == '0) begin
                st_d.ctl = csr_wdata & CTL_KEEP;
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (int'(idx) == i) begin
                case (kind)
                    CK_BASE: csr_rdata = CSR_DW'(st_q.win[i].base);
                    CK_MASK: csr_rdata = CSR_DW'(st_q.win[i].mask);
                    CK_TBA:  csr_rdata = CSR_DW'(st_q.win[i].tba);
                    default: ;
                endcase
            end
        end
        if (kind == CK_CTL && idx == '0) begin
            csr_rdata = st_q.ctl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_value();
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o = st_q.win;
    assign ctl_o = st_q.ctl;

endmodule

// File: rtl/dwx_win.sv
module dwx_win import dwx_pkg::*; (
    input  win_cfg_t          cfg,
    input  logic [31:0]       addr_lo,
    output logic              hit,
    output logic              sg,
    output logic [SYS_AW-1:0] dm_addr,
    output logic [SYS_AW-1:0] dm_mask,
    output logic [SYS_AW-1:0] pte_addr
);

    logic [31:0]       ext;
    logic [SYS_AW-1:0] ext_w;
    logic [SYS_AW-1:0] tba_clr;
    logic [SYS_AW-1:0] idx_part;
    logic              unused_cfg;

    always_comb begin
        ext      = cfg.mask | WIN_FLOOR;
        ext_w    = SYS_AW'(ext);
        hit      = cfg.base[BASE_EN_BIT] &&
                   ((addr_lo & ~ext) == {cfg.base[31:20], 20'h0_0000});
        sg       = cfg.base[BASE_SG_BIT];
        dm_mask  = ext_w;
        dm_addr  = (cfg.tba & ~ext_w) | (SYS_AW'(addr_lo) & ext_w);
        tba_clr  = SYS_AW'(cfg.mask >> 10);
        idx_part = SYS_AW'((addr_lo & (cfg.mask | SG_IDX_BITS)) >> 10);
        pte_addr = (cfg.tba & ~tba_clr) | idx_part;
    end

    assign unused_cfg = ^{cfg.base[BASE_W-1:32], cfg.base[19:2], cfg.mask[19:0]};

endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate import dwx_pkg::*; #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int CSR_AW = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [CSR_DW-1:0]  csr_wdata,
    output logic [CSR_DW-1:0]  csr_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PCI_AW-1:0]  req_addr,
    output logic               pte_req_valid,
    output logic [SYS_AW-1:0]  pte_req_addr,
    input  logic               pte_rsp_valid,
    input  logic [CSR_DW-1:0]  pte_rsp_data,
    output logic               res_valid,
    output logic               res_fault,
    output logic [SYS_AW-1:0]  res_addr,
    output logic [SYS_AW-1:0]  res_mask
);

    win_cfg_t [NUM_WIN-1:0] win_cfg;
    logic [CSR_DW-1:0]      ctl;

    dwx_csr #(.NUM_WIN(NUM_WIN)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .win_o     (win_cfg),
        .ctl_o     (ctl)
    );

    logic [NUM_WIN-1:0] w_hit;
    logic [NUM_WIN-1:0] w_sg;
    logic [SYS_AW-1:0]  w_dm_a [NUM_WIN];
    logic [SYS_AW-1:0]  w_dm_m [NUM_WIN];
    logic [SYS_AW-1:0]  w_pte  [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dwx_win u_win (
            .cfg      (win_cfg[g]),
            .addr_lo  (req_addr[31:0]),
            .hit      (w_hit[g]),
            .sg       (w_sg[g]),
            .dm_addr  (w_dm_a[g]),
            .dm_mask  (w_dm_m[g]),
            .pte_addr (w_pte[g])
        );
    end

    // address class decode
    logic              sac, in_hole, big_rng, dac_rng, last_dac_on;
    logic              found, f_sg;
    logic [SYS_AW-1:0] f_dm_a, f_dm_m, f_pte, dac_pte;
    outcome_e          oc;
    logic [SYS_AW-1:0] oc_addr, oc_mask, oc_pte;

    always_comb begin
        sac         = (req_addr[PCI_AW-1:32] == '0);
        in_hole     = ctl[CTL_HOLE_BIT] && sac &&
                      (req_addr[31:0] >= HOLE_LO) && (req_addr[31:0] <= HOLE_HI);
        big_rng     = (req_addr[PCI_AW-1:40] == 4'h1);
        dac_rng     = req_addr[PCI_AW-1];
        last_dac_on = win_cfg[NUM_WIN-1].base[BASE_DAC_BIT];
        dac_pte     = (win_cfg[NUM_WIN-1].tba & DAC_TBA_KEEP) |
                      SYS_AW'((req_addr[31:0] & DAC_IDX_BITS) >> 10);

        found  = 1'b0;
        f_sg   = 1'b0;
        f_dm_a = '0;
        f_dm_m = '0;
        f_pte  = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (!found && w_hit[i] && ((i != NUM_WIN - 1) || !last_dac_on)) begin
                found  = 1'b1;
                f_sg   = w_sg[i];
                f_dm_a = w_dm_a[i];
                f_dm_m = w_dm_m[i];
                f_pte  = w_pte[i];
            end
        end

        oc      = OC_FAULT;
        oc_addr = '0;
        oc_mask = '0;
        oc_pte  = '0;
        if (sac) begin
            if (!in_hole && found) begin
                if (f_sg) begin
                    oc     = OC_TABLE;
                    oc_pte = f_pte;
                end else begin
                    oc      = OC_DIRECT;
                    oc_addr = f_dm_a;
                    oc_mask = f_dm_m;
                end
            end
        end else if (big_rng) begin
            if (ctl[CTL_BIG_BIT]) begin
                oc      = OC_DIRECT;
                oc_addr = req_addr[SYS_AW-1:0];
                oc_mask = BIG_MASK;
            end
        end else if (dac_rng) begin
            if (last_dac_on && win_cfg[NUM_WIN-1].base[BASE_EN_BIT]) begin
                oc     = OC_TABLE;
                oc_pte = dac_pte;
            end
        end
    end

    // sequencer
    xl_t x_d, x_q;

    always_comb begin
        x_d       = x_q;
        x_d.res_v = 1'b0;
        unique case (x_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (oc)
                        OC_DIRECT: begin
                            x_d.res_v = 1'b1;
                            x_d.res_f = 1'b0;
                            x_d.res_a = oc_addr;
                            x_d.res_m = oc_mask;
                        end
                        OC_TABLE: begin
                            x_d.st    = ST_ISSUE;
                            x_d.pte_a = oc_pte;
                            x_d.off   = req_addr[PG_OFF_W-1:0];
                        end
                        default: begin
                            x_d.res_v = 1'b1;
                            x_d.res_f = 1'b1;
                            x_d.res_a = '0;
                            x_d.res_m = '0;
                        end
                    endcase
                end
            end
            ST_ISSUE: begin
                x_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (pte_rsp_valid) begin
                    x_d.st    = ST_IDLE;
                    x_d.res_v = 1'b1;
                    if (pte_rsp_data[0]) begin
                        x_d.res_f = 1'b0;
                        x_d.res_a = {1'b0, pte_rsp_data[21:1], x_q.off};
                        x_d.res_m = PG_MASK;
                    end else begin
                        x_d.res_f = 1'b1;
                        x_d.res_a = '0;
                        x_d.res_m = '0;
                    end
                end
            end
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign req_ready     = (x_q.st == ST_IDLE);
    assign pte_req_valid = (x_q.st == ST_ISSUE);
    assign pte_req_addr  = x_q.pte_a;
    assign res_valid     = x_q.res_v;
    assign res_fault     = x_q.res_f;
    assign res_addr      = x_q.res_a;
    assign res_mask      = x_q.res_m;

    logic unused_bits;
    assign unused_bits = ^{ctl[CSR_DW-1:7], ctl[4:0], pte_rsp_data[CSR_DW-1:22]};

endmodule

// File: rtl/dwx_chk.sv
module dwx_chk import dwx_pkg::*; #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int CSR_AW = IDX_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [CSR_DW-1:0] csr_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic              pte_req_valid,
    input logic              pte_rsp_valid,
    input logic              res_valid,
    input logic              res_fault,
    input logic [SYS_AW-1:0] res_addr,
    input logic [SYS_AW-1:0] res_mask
);

    localparam logic [CSR_AW-1:0] LAST_BASE_SEL = {CK_BASE, IDX_W'(NUM_WIN - 1)};

    // R2
    last_sg_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == LAST_BASE_SEL) |-> csr_rdata[BASE_SG_BIT]);

    // R4
    accept_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (res_valid || pte_req_valid));

    // R5
    fetch_pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pte_req_valid |-> (!req_ready ##1 (!pte_req_valid && !req_ready)));

    // R6
    result_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(req_valid && req_ready) || $past(pte_rsp_valid && !req_ready)));

    // R11
    fault_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_addr == '0 && res_mask == '0));

endmodule

bind dma_win_xlate dwx_chk #(.NUM_WIN(NUM_WIN)) i_dwx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_addr      (csr_addr),
    .csr_rdata     (csr_rdata),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .pte_req_valid (pte_req_valid),
    .pte_rsp_valid (pte_rsp_valid),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .res_addr      (res_addr),
    .res_mask      (res_mask)
);

// File: tb/test_dma_win_xlate.sv
`timescale 1ns/1ps
module test_dma_win_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [43:0] req_addr = '0;
    logic        pte_req_valid;
    logic [34:0] pte_req_addr;
    logic        pte_rsp_valid = 1'b0;
    logic [63:0] pte_rsp_data = '0;
    logic        res_valid, res_fault;
    logic [34:0] res_addr, res_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dma_win_xlate i_dma_win_xlate (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .pte_req_valid(pte_req_valid), .pte_req_addr(pte_req_addr),
        .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_addr(res_addr), .res_mask(res_mask)
    );

    localparam logic [3:0] A_CTL = 4'd12;
    function automatic logic [3:0] a_base(int w); return 4'(w);     endfunction
    function automatic logic [3:0] a_mask(int w); return 4'(4 + w); endfunction
    function automatic logic [3:0] a_tba(int w);  return 4'(8 + w); endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [63:0] exp);
        @(negedge clk);
        csr_addr = a;
        #1;
        chk(req, "csr readback", csr_rdata, exp);
    endtask

    task automatic xlate(input string req, input logic [43:0] a, input bit use_pte,
                         input logic [34:0] exp_pa, input logic [63:0] pte,
                         input bit exp_fault, input logic [34:0] exp_addr, input logic [34:0] exp_mask);
        @(negedge clk);
        chk(req, "ready before", {63'b0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (use_pte) begin
            chk(req, "fetch strobe", {63'b0, pte_req_valid}, 64'd1);
            chk(req, "fetch address", {29'b0, pte_req_addr}, {29'b0, exp_pa});
            chk(req, "ready while busy", {63'b0, req_ready}, 64'd0);
            chk(req, "no early result", {63'b0, res_valid}, 64'd0);
            @(negedge clk);
            chk(req, "fetch one cycle", {63'b0, pte_req_valid}, 64'd0);
            chk(req, "ready while waiting", {63'b0, req_ready}, 64'd0);
            pte_rsp_valid = 1'b1; pte_rsp_data = pte;
            @(negedge clk);
            pte_rsp_valid = 1'b0;
        end else begin
            chk(req, "no fetch", {63'b0, pte_req_valid}, 64'd0);
        end
        chk(req, "result strobe", {63'b0, res_valid}, 64'd1);
        chk(req, "fault flag", {63'b0, res_fault}, {63'b0, exp_fault});
        chk(req, "result address", {29'b0, res_addr}, {29'b0, exp_addr});
        chk(req, "result mask", {29'b0, res_mask}, {29'b0, exp_mask});
    endtask

    task automatic expect_fault(input string req, input logic [43:0] a);
        xlate(req, a, 1'b0, '0, '0, 1'b1, '0, '0);
    endtask

    task automatic expect_direct(input string req, input logic [43:0] a,
                                 input logic [34:0] ea, input logic [34:0] em);
        xlate(req, a, 1'b0, '0, '0, 1'b0, ea, em);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready", {63'b0, req_ready}, 64'd1);
        chk("R1", "result idle", {63'b0, res_valid}, 64'd0);
        chk("R1", "fetch idle", {63'b0, pte_req_valid}, 64'd0);
        rd_chk("R1", a_base(3), 64'h2);
        rd_chk("R1", a_base(0), 64'h0);
        rd_chk("R1", a_tba(2), 64'h0);
        rd_chk("R1", A_CTL, 64'h0);
        expect_fault("R1", 44'h0_4000_0000);
    endtask

    task automatic t_write_masks();
        wr(a_base(0), '1);  rd_chk("R2", a_base(0), 64'hFFF0_0003);
        wr(a_base(3), '1);  rd_chk("R2", a_base(3), 64'h80_FFF0_0003);
        wr(a_base(3), '0);  rd_chk("R2", a_base(3), 64'h2);
        wr(a_mask(1), '1);  rd_chk("R2", a_mask(1), 64'hFFF0_0000);
        wr(a_tba(0), '1);   rd_chk("R2", a_tba(0), 64'h7_FFFF_FC00);
        wr(A_CTL, '1);      rd_chk("R2", A_CTL, 64'h1C_FF0F_C7FF);
        wr(A_CTL, '0);
        wr(a_mask(1), '0);
    endtask

    task automatic t_direct();
        wr(a_base(0), 64'h4000_0001);
        wr(a_mask(0), 64'h0010_0000);
        wr(a_tba(0),  64'h1_2340_0000);
        expect_direct("R4", 44'h0_4012_3456, 35'h1_2352_3456, 35'h1F_FFFF);
        expect_fault("R3", 44'h0_4020_0000);
        wr(a_base(0), 64'h4000_0000);
        expect_fault("R3", 44'h0_4012_3456);
    endtask

    task automatic t_priority();
        wr(a_base(0), 64'h4000_0001);
        wr(a_base(2), 64'h4000_0001);
        wr(a_mask(2), 64'h0);
        wr(a_tba(2),  64'h0_5500_0000);
        expect_direct("R7", 44'h0_4001_2345, 35'h1_2341_2345, 35'h1F_FFFF);
        wr(a_base(0), 64'h4000_0000);
        expect_direct("R7", 44'h0_4001_2345, 35'h0_5501_2345, 35'h0F_FFFF);
    endtask

    task automatic t_table();
        wr(a_base(1), 64'h8000_0003);
        wr(a_mask(1), 64'h0);
        wr(a_tba(1),  64'h2_0000_0000);
        xlate("R5", 44'h0_8004_6123, 1'b1, 35'h2_0000_0118, 64'h12_3457,
              1'b0, 35'h1_2345_6123, 35'h1FFF);
        xlate("R6", 44'h0_8004_6123, 1'b1, 35'h2_0000_0118, 64'h12_3456,
              1'b1, '0, '0);
        wr(a_mask(1), 64'h0030_0000);
        wr(a_tba(1),  64'h2_0000_0C00);
        xlate("R5", 44'h0_8025_A000, 1'b1, 35'h2_0000_0968, 64'h3,
              1'b0, 35'h0_0000_2000, 35'h1FFF);
    endtask

    task automatic t_last_window();
        wr(a_mask(3), 64'h0);
        wr(a_tba(3),  64'h3_0000_0000);
        wr(a_base(3), 64'hC000_0001);
        rd_chk("R2", a_base(3), 64'hC000_0003);
        xlate("R7", 44'h0_C000_2000, 1'b1, 35'h3_0000_0008, 64'h801,
              1'b0, 35'h0_0080_0000, 35'h1FFF);
        wr(a_base(3), 64'h80_C000_0001);
        expect_fault("R7", 44'h0_C000_2000);
        wr(a_tba(3),  64'h3_0030_0400);
        xlate("R10", 44'h800_0001_2000, 1'b1, 35'h3_0000_0048, 64'h3F_FFFF,
              1'b0, 35'h3_FFFF_E000, 35'h1FFF);
        xlate("R10", 44'hFFF_8000_2ABC, 1'b1, 35'h3_0020_0008, 64'h801,
              1'b0, 35'h0_0080_0ABC, 35'h1FFF);
        wr(a_base(3), 64'h80_C000_0000);
        expect_fault("R10", 44'h800_0001_2000);
    endtask

    task automatic t_hole();
        wr(a_base(0), 64'h0000_0001);
        wr(a_mask(0), 64'h0);
        wr(a_tba(0),  64'h1_0000_0000);
        expect_direct("R8", 44'h0_0009_0000, 35'h1_0009_0000, 35'h0F_FFFF);
        wr(A_CTL, 64'h20);
        expect_fault("R8", 44'h0_0008_0000);
        expect_fault("R8", 44'h0_000F_FFFF);
        expect_direct("R8", 44'h0_0007_FFFF, 35'h1_0007_FFFF, 35'h0F_FFFF);
    endtask

    task automatic t_big();
        wr(A_CTL, 64'h40);
        expect_direct("R9", 44'h1AB_CDEF_0123, 35'h3_CDEF_0123, 35'h7_FFFF_FFFF);
        expect_direct("R9", 44'h100_0000_0000, 35'h0, 35'h7_FFFF_FFFF);
        expect_fault("R9", 44'h200_0000_0000);
        wr(A_CTL, 64'h0);
        expect_fault("R9", 44'h1AB_CDEF_0123);
    endtask

    task automatic t_unmapped();
        expect_fault("R12", 44'h001_0000_0000);
        expect_fault("R12", 44'h0FF_FFFF_FFFF);
        expect_fault("R12", 44'h7FF_FFFF_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_masks();
        t_direct();
        t_priority();
        t_table();
        t_last_window();
        t_hole();
        t_big();
        t_unmapped();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule